// File: doc/BRIEF.md
# Debug Watchpoint Signal Generator

This block watches the instruction fetch stream and the data access stream of a processor. It compares each address against a set of programmable compare registers: four for instruction addresses and two for data addresses. Every raw match is reported on a registered 6-bit watchpoint vector for external monitoring logic. Separately, a per-event enable in a control register decides whether a match also latches a sticky debug status bit. Software clears a status bit by writing a one to it.

Each data comparator has a load qualifier and a store qualifier. When both qualifiers of a data event are clear, the event is fully disabled for status, and its watchpoint falls back to firing on loads and on stores alike. When only one qualifier is set, only accesses of that type are observed, for both the watchpoint and the status bit. The two access inputs are valid-strobed streams with no ready signal. The block takes one fetch and one data access in every cycle and never applies back-pressure, so a source may present a new access on every clock.

Top module: `dbg_watchpoint_unit`

## Requirements
- R1: Register writes use `reg_wr_en`, `reg_wr_addr` and `reg_wr_data`, and take effect at the clock edge where `reg_wr_en` is high. The address map is:
  - addresses 0 to 3 hold instruction compares 1 to 4;
  - addresses 4 and 5 hold data compares 1 and 2;
  - address 6 is the control register;
  - address 7 is the status clear port.
- R1 (control register layout): control bit i (0..3) enables status for instruction compare i+1. Bit 4 is the load qualifier and bit 5 the store qualifier of data compare 1. Bit 6 is the load qualifier and bit 7 the store qualifier of data compare 2.
- R2: `watch_o` bits 0 to 3 report instruction compares 1 to 4, and bits 4 and 5 report data compares 1 and 2. Each bit is registered and is high in the cycle after the clock edge that samples the matching access.
- R3: An instruction compare matches only while `ifetch_valid` is high and `ifetch_addr` equals the compare register, with address bits [1:0] ignored.
- R4: A data compare matches only while `dacc_valid` is high and `dacc_addr` equals the compare register in every bit.
- R5: A watchpoint bit fires on a match even when its event is not enabled to set status.
- R6: A data event whose load and store qualifiers are both clear fires its watchpoint on matching loads (`dacc_is_store`=0) and on matching stores (`dacc_is_store`=1).
- R7: A data event with only one qualifier set ignores matching accesses of the other type: no watchpoint and no status.
- R8: A status bit sets only when its event is enabled and matches, and it holds until cleared. For data events, "enabled" means the qualifier that belongs to the access type is set.
- R9: Writing address 7 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. A set and a clear of the same bit in one cycle leave the bit set.
- R10: Each matching access gives a one-cycle pulse. Matches in consecutive cycles give consecutive high cycles, and the bit drops in the first cycle after an access that does not match.
- R11: Reset (active-low `rst_n`, asynchronous) clears all compare registers, the control register, `status_o` and `watch_o`.
- R12: Both access inputs are accepted in every cycle without back-pressure, and instruction and data watchpoints can fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| ifetch_valid | input | 1 | Instruction fetch address valid |
| ifetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access valid |
| dacc_addr | input | 32 | Data access address |
| dacc_is_store | input | 1 | 1 = store access, 0 = load access |
| watch_o | output | 6 | Registered watchpoint pulses |
| status_o | output | 6 | Sticky debug status bits |

## Verification
The bench targets the following corner cases, each chosen to expose a specific design error:
- **Fully disabled data event.** A design that treats both qualifiers clear as "never match" would stay silent on loads and stores.
- **Single-qualifier event.** A design that ignores the access type would raise a watchpoint or status bit on the wrong access type.
- **Watchpoint versus status enable.** Matches on events not enabled for status are checked, because a design that gates the watchpoint by the enable would drop those pulses.
- **Address compares.** Bits [1:0] must be ignored on fetch compares, and an off-by-one data address must not match.
- **Status clear.** The bench checks the write-one-to-clear mask, and the same-cycle set and clear where a wrong priority loses an event.
- **Reset.** Reset is checked both at start-up and mid-run, so leftover compare or control contents would show up as wrong pulses on address zero.

// File: rtl/dbgwp_pkg.sv
`timescale 1ns/1ps
package dbgwp_pkg;
  // Offsets inside the register window, relative to the block layout
  localparam int unsigned IAC_BASE = 0;
  // Control field per data event: {store_qual, load_qual}
  localparam int unsigned DAC_QUAL_W = 2;
  localparam int unsigned QUAL_LD    = 0;
  localparam int unsigned QUAL_ST    = 1;
endpackage

// File: rtl/dbgwp_regs.sv
`timescale 1ns/1ps
module dbgwp_regs #(
  parameter int unsigned AW     = 32,
  parameter int unsigned N_IAC  = 4,
  parameter int unsigned N_DAC  = 2,
  parameter int unsigned RAW    = 3,
  parameter int unsigned CTRL_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RAW-1:0]             wr_addr,
  input  logic [AW-1:0]              wr_data,
  output logic [N_IAC-1:0][AW-1:0]   iac_cmp,
  output logic [N_DAC-1:0][AW-1:0]   dac_cmp,
  output logic [CTRL_W-1:0]          ctrl
);
  import dbgwp_pkg::*;

  localparam int unsigned DAC_BASE  = IAC_BASE + N_IAC;
  localparam int unsigned CTRL_ADDR = DAC_BASE + N_DAC;

  for (genvar i = 0; i < N_IAC; i++) begin : g_iac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        iac_cmp[i] <= '0;
      else if (wr_en && wr_addr == RAW'(IAC_BASE + i))
        iac_cmp[i] <= wr_data;
    end
  end

  for (genvar k = 0; k < N_DAC; k++) begin : g_dac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dac_cmp[k] <= '0;
      else if (wr_en && wr_addr == RAW'(DAC_BASE + k))
        dac_cmp[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && wr_addr == RAW'(CTRL_ADDR))
      ctrl <= wr_data[CTRL_W-1:0];
  end
endmodule

// File: rtl/dbgwp_match.sv
`timescale 1ns/1ps
module dbgwp_match #(
  parameter int unsigned AW     = 32,
  parameter int unsigned N_IAC  = 4,
  parameter int unsigned N_DAC  = 2,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned N_EV   = 6
) (
  input  logic [N_IAC-1:0][AW-1:0]   iac_cmp,
  input  logic [N_DAC-1:0][AW-1:0]   dac_cmp,
  input  logic [CTRL_W-1:0]          ctrl,
  input  logic                       ifetch_valid,
  input  logic [AW-1:0]              ifetch_addr,
  input  logic                       dacc_valid,
  input  logic [AW-1:0]              dacc_addr,
  input  logic                       dacc_is_store,
  output logic [N_EV-1:0]            hit,
  output logic [N_EV-1:0]            set_req
);
  import dbgwp_pkg::*;

  // Instruction compares look at word addresses only
  localparam logic [AW-1:0] IAC_MASK = ~AW'(3);

  for (genvar i = 0; i < N_IAC; i++) begin : g_iac
    logic eq;
    assign eq         = ((ifetch_addr ^ iac_cmp[i]) & IAC_MASK) == '0;
    assign hit[i]     = ifetch_valid && eq;
    assign set_req[i] = ifetch_valid && eq && ctrl[i];
  end

  for (genvar k = 0; k < N_DAC; k++) begin : g_dac
    logic ld_q, st_q, raw, typed, open;
    assign ld_q  = ctrl[N_IAC + DAC_QUAL_W*k + QUAL_LD];
    assign st_q  = ctrl[N_IAC + DAC_QUAL_W*k + QUAL_ST];
    assign raw   = dacc_valid && (dacc_addr == dac_cmp[k]);
    assign typed = dacc_is_store ? st_q : ld_q;
    assign open  = !ld_q && !st_q;
    assign hit[N_IAC + k]     = raw && (typed || open);
    assign set_req[N_IAC + k] = raw && typed;
  end
endmodule

// File: rtl/dbgwp_status.sv
`timescale 1ns/1ps
module dbgwp_status #(
  parameter int unsigned N_EV = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] set_req,
  input  logic [N_EV-1:0] clr_req,
  output logic [N_EV-1:0] status
);
  // Set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else
      status <= (status & ~clr_req) | set_req;
  end
endmodule

// File: rtl/dbg_watchpoint_unit.sv
`timescale 1ns/1ps
module dbg_watchpoint_unit #(
  parameter int unsigned AW    = 32,
  parameter int unsigned N_IAC = 4,
  parameter int unsigned N_DAC = 2,
  localparam int unsigned N_EV   = N_IAC + N_DAC,
  localparam int unsigned RAW    = $clog2(N_EV + 2),
  localparam int unsigned CTRL_W = N_IAC + 2*N_DAC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [RAW-1:0]  reg_wr_addr,
  input  logic [AW-1:0]   reg_wr_data,
  input  logic            ifetch_valid,
  input  logic [AW-1:0]   ifetch_addr,
  input  logic            dacc_valid,
  input  logic [AW-1:0]   dacc_addr,
  input  logic            dacc_is_store,
  output logic [N_EV-1:0] watch_o,
  output logic [N_EV-1:0] status_o
);
  localparam int unsigned STAT_ADDR = N_EV + 1;

  logic [N_IAC-1:0][AW-1:0] iac_cmp;
  logic [N_DAC-1:0][AW-1:0] dac_cmp;
  logic [CTRL_W-1:0]        ctrl;
  logic [N_EV-1:0]          hit, set_req, clr_req;
  logic [N_EV-1:0]          watch_q;

  dbgwp_regs #(.AW(AW), .N_IAC(N_IAC), .N_DAC(N_DAC), .RAW(RAW), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .iac_cmp(iac_cmp), .dac_cmp(dac_cmp), .ctrl(ctrl)
  );

  dbgwp_match #(.AW(AW), .N_IAC(N_IAC), .N_DAC(N_DAC), .CTRL_W(CTRL_W), .N_EV(N_EV)) u_match (
    .iac_cmp(iac_cmp), .dac_cmp(dac_cmp), .ctrl(ctrl),
    .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
    .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_is_store(dacc_is_store),
    .hit(hit), .set_req(set_req)
  );

  assign clr_req = (reg_wr_en && reg_wr_addr == RAW'(STAT_ADDR)) ? reg_wr_data[N_EV-1:0] : '0;

  dbgwp_status #(.N_EV(N_EV)) u_status (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req), .status(status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) watch_q <= '0;
    else        watch_q <= hit;
  end
  assign watch_o = watch_q;
endmodule

// File: rtl/dbgwp_checker.sv
`timescale 1ns/1ps
module dbgwp_checker #(
  parameter int unsigned N_IAC     = 4,
  parameter int unsigned N_EV      = 6,
  parameter int unsigned RAW       = 3,
  parameter int unsigned STAT_ADDR = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [RAW-1:0]  reg_wr_addr,
  input logic [N_EV-1:0] clr_data,
  input logic            ifetch_valid,
  input logic            dacc_valid,
  input logic [N_EV-1:0] watch_o,
  input logic [N_EV-1:0] status_o
);
  logic [N_EV-1:0] clr_seen;
  assign clr_seen = (reg_wr_en && reg_wr_addr == RAW'(STAT_ADDR)) ? clr_data : '0;

  // R3: no fetch sampled, no instruction watchpoint the next cycle
  a_r3_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ifetch_valid) |-> (watch_o[N_IAC-1:0] == '0));

  // R4: no data access sampled, no data watchpoint the next cycle
  a_r4_data_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dacc_valid) |-> (watch_o[N_EV-1:N_IAC] == '0));

  // R8: status bits hold unless a clear was written
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_o) & ~$past(clr_seen) & ~status_o) == '0));

  // R8: a newly set status bit comes with its watchpoint pulse
  a_r8_set_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_o & ~$past(status_o)) & ~watch_o) == '0));

  // R11: outputs held clear while reset is asserted
  a_r11_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (watch_o == '0 && status_o == '0));
endmodule

bind dbg_watchpoint_unit dbgwp_checker #(
  .N_IAC(N_IAC), .N_EV(N_EV), .RAW(RAW), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .clr_data(reg_wr_data[N_EV-1:0]), .ifetch_valid(ifetch_valid),
  .dacc_valid(dacc_valid), .watch_o(watch_o), .status_o(status_o)
);

// File: tb/dbg_watchpoint_unit_test.sv
`timescale 1ns/1ps
module dbg_watchpoint_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic        ifetch_valid;
  logic [31:0] ifetch_addr;
  logic        dacc_valid;
  logic [31:0] dacc_addr;
  logic        dacc_is_store;
  logic [5:0]  watch_o;
  logic [5:0]  status_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbg_watchpoint_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
    .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_is_store(dacc_is_store),
    .watch_o(watch_o), .status_o(status_o)
  );

  typedef struct packed {
    logic        iv;
    logic [31:0] ia;
    logic        dv;
    logic [31:0] da;
    logic        ds;
    logic [5:0]  exp;
  } vec_t;

  // Setup: IAC 0x1000/0x2000/0x3000/0x4000, DAC1 0x80000010 (fully
  // disabled), DAC2 0x80000020 (load only), IAC1 and IAC3 status-enabled.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 1'b0, 32'h0,         1'b0, 6'b000001}, // R2 R3 exact
    '{1'b1, 32'h0000_2003, 1'b0, 32'h0,         1'b0, 6'b000010}, // R3 low bits ignored, R5 not enabled
    '{1'b1, 32'h0000_3004, 1'b0, 32'h0,         1'b0, 6'b000000}, // R3 next word misses
    '{1'b0, 32'h0000_4000, 1'b0, 32'h0,         1'b0, 6'b000000}, // R3 no valid
    '{1'b0, 32'h0,         1'b1, 32'h8000_0010, 1'b0, 6'b010000}, // R6 load
    '{1'b0, 32'h0,         1'b1, 32'h8000_0010, 1'b1, 6'b010000}, // R6 store
    '{1'b0, 32'h0,         1'b1, 32'h8000_0020, 1'b0, 6'b100000}, // R2 DAC2 load
    '{1'b0, 32'h0,         1'b1, 32'h8000_0020, 1'b1, 6'b000000}, // R7 store ignored
    '{1'b0, 32'h0,         1'b1, 32'h8000_0021, 1'b0, 6'b000000}, // R4 exact compare
    '{1'b1, 32'h0000_4000, 1'b1, 32'h8000_0010, 1'b0, 6'b011000}  // R12 both streams
  };

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic iv, input logic [31:0] ia,
                      input logic dv, input logic [31:0] da, input logic ds);
    @(negedge clk);
    reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
    ifetch_valid = iv; ifetch_addr = ia;
    dacc_valid = dv; dacc_addr = da; dacc_is_store = ds;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] wa, input logic [31:0] wd);
    step(1'b1, wa, wd, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic fin();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    fin();
  end

  initial begin
    rst_n = 1'b1;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    ifetch_valid = 1'b0; ifetch_addr = '0;
    dacc_valid = 1'b0; dacc_addr = '0; dacc_is_store = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 watch in reset", watch_o, 6'b0);
    chk("R11 status in reset", status_o, 6'b0);
    @(negedge clk) rst_n = 1'b1;

    // R11: cleared compares hit address 0, cleared control opens both DACs
    step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 1'b1, 32'h0, 1'b0);
    chk("R11 cleared compares", watch_o, 6'b111111);
    chk("R11 cleared control", status_o, 6'b0);

    // R1: program the register map
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'h0000_3000);
    wr(3'd3, 32'h0000_4000);
    wr(3'd4, 32'h8000_0010);
    wr(3'd5, 32'h8000_0020);
    wr(3'd6, 32'h0000_0045);
    idle();
    chk("R10 idle after writes", watch_o, 6'b0);

    for (int n = 0; n < NV; n++) begin
      step(1'b0, 3'd0, 32'h0, VECS[n].iv, VECS[n].ia, VECS[n].dv, VECS[n].da, VECS[n].ds);
      chk($sformatf("R2 vector %0d", n), watch_o, VECS[n].exp);
    end
    idle();
    // R8 R5: only IAC1 and DAC2-load latched status
    chk("R8 status after table", status_o, 6'b100001);

    // R9: write-one-to-clear
    wr(3'd7, 32'h0000_0001);
    chk("R9 clear bit0", status_o, 6'b100000);
    wr(3'd7, 32'h0000_0000);
    chk("R9 zero write keeps", status_o, 6'b100000);
    step(1'b1, 3'd7, 32'h0000_0020, 1'b0, 32'h0, 1'b1, 32'h8000_0020, 1'b0);
    chk("R9 set beats clear", status_o, 6'b100000);
    chk("R9 watch on set-clear", watch_o, 6'b100000);
    wr(3'd7, 32'h0000_0020);
    chk("R9 clear bit5", status_o, 6'b0);

    // R7: store to a load-only DAC sets no status
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h8000_0020, 1'b1);
    chk("R7 store watch", watch_o, 6'b0);
    chk("R7 store status", status_o, 6'b0);

    // R10: back-to-back pulses then drop
    step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0);
    chk("R10 first pulse", watch_o, 6'b000001);
    step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0);
    chk("R10 second pulse", watch_o, 6'b000001);
    idle();
    chk("R10 drop", watch_o, 6'b0);
    wr(3'd7, 32'h0000_003F);

    // R7 R6: DAC1 store-only, DAC2 fully disabled, IACs off
    wr(3'd6, 32'h0000_0020);
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h8000_0010, 1'b0);
    chk("R7 load ignored", watch_o, 6'b0);
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h8000_0010, 1'b1);
    chk("R7 store seen", watch_o, 6'b010000);
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h8000_0020, 1'b1);
    chk("R6 disabled DAC2 store", watch_o, 6'b100000);
    chk("R8 status store-only", status_o, 6'b010000);

    // R12 R5: simultaneous fetch and data match, IAC3 not enabled
    step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_3000, 1'b1, 32'h8000_0010, 1'b1);
    chk("R12 simultaneous", watch_o, 6'b010100);

    // R11: mid-run reset clears everything
    @(negedge clk) rst_n = 1'b0;
    idle();
    #1;
    chk("R11 mid reset status", status_o, 6'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 1'b1, 32'h0, 1'b1);
    chk("R11 regs cleared mid-run", watch_o, 6'b111111);
    chk("R11 status stays clear", status_o, 6'b0);

    fin();
  end
endmodule